// File: doc/BRIEF.md
# Single-Step Non-Restoring Division Unit

This block performs one iteration of a one-bit non-restoring division. It takes a divisor, a partial remainder and three status bits: the previous quotient/sign bit (Q), the divisor-sign mode bit (M) and the incoming quotient/carry bit (T). It returns the next partial remainder together with new Q and T values. The remainder is shifted left, and T enters at the bottom. The divisor is then added or subtracted, depending on whether the previous Q agrees with M. The new Q comes from the bit shifted out, the carry or borrow of that operation, and M. The new T is the quotient bit this step produces.

A host first clears or sets Q and M with its own initialisation step. It then calls the unit once per quotient bit, W times in total. Between calls it rotates the dividend through T, which collects the quotient bits. The result is registered. A step is requested by holding `start` high, and its result appears with `valid` one clock later. M is an input only, and the unit never returns or alters it.

Top module: `div1_unit`

## Requirements
- R1: In the cycle after a clock edge with `rst` high, `valid`, `rem_out`, `q_out` and `t_out` are all 0.
- R2: A clock edge with `start` high gives `valid` = 1 after that edge. A clock edge with `start` low gives `valid` = 0, and `rem_out`, `q_out` and `t_out` keep their previous values.
- R3: The operand is the shifted remainder S = {rem_in[W-2:0], t_in}. The old top bit rem_in[W-1] leaves the word, and t_in becomes bit 0.
- R4: When q_in equals m_in, rem_out = (S - divisor) mod 2^W, and the carry/borrow bit C is 1 exactly when S < divisor (unsigned borrow).
- R5: When q_in differs from m_in, rem_out = (S + divisor) mod 2^W, and C is 1 exactly when S + divisor ≥ 2^W (unsigned carry).
- R6: q_out = rem_in[W-1] XOR C XOR m_in.
- R7: t_out = 1 when q_out equals m_in, and 0 otherwise.
- R8: Starting from Q = M = T = 0 and a zero remainder, a host rotates the dividend left through T before each step: T takes the dividend MSB, and the old T enters the dividend LSB. After W steps, one final rotation of T into the dividend LSB leaves floor(dividend / divisor) in the dividend word. This holds for every nonzero divisor, including divisors with the MSB set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Perform one step on this clock edge |
| divisor | input | W | Divisor operand |
| rem_in | input | W | Current partial remainder |
| q_in | input | 1 | Previous Q status bit |
| m_in | input | 1 | M status bit (divisor sign mode) |
| t_in | input | 1 | Incoming T bit, inserted at remainder bit 0 |
| rem_out | output | W | Updated partial remainder |
| q_out | output | 1 | New Q status bit |
| t_out | output | 1 | New T bit (quotient bit of this step) |
| valid | output | 1 | Result of a step is present |

## Verification
With a 6-bit word, every step is run for every remainder, every divisor and all eight Q/M/T combinations. This covers the subtract path (Q equal to M) and the add path (Q differing from M), both with and without a carry or borrow, and with the MSB shifted out both 0 and 1. Each result is compared with modular arithmetic worked out in the bench. A zero divisor isolates the shift and the T insertion, since the add and subtract paths then leave S unchanged. Full divisions of every dividend by every nonzero divisor confirm that the chained steps yield the unsigned quotient. Divisors at or above half range are included, and they exercise the wrap of the add and subtract paths. A cycle with `start` low confirms that the outputs hold and that `valid` drops.

// File: rtl/div1_pkg.sv
package div1_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } div1_op_e;
endpackage

// File: rtl/div1_alu.sv
module div1_alu
  import div1_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] opnd,
  input  logic [W-1:0] divisor,
  input  div1_op_e     op,
  output logic [W-1:0] res,
  output logic         cb
);
  localparam int XW = W + 1;

  logic [XW-1:0] wide;

  always_comb begin
    if (op == OP_SUB) begin
      wide = {1'b0, opnd} - {1'b0, divisor};
    end else begin
      wide = {1'b0, opnd} + {1'b0, divisor};
    end
    res = wide[W-1:0];
    cb  = wide[XW-1];
  end
endmodule

// File: rtl/div1_flags.sv
module div1_flags (
  input  logic shifted_out,
  input  logic cb,
  input  logic m_in,
  output logic q_new,
  output logic t_new
);
  always_comb begin
    q_new = shifted_out ^ cb ^ m_in;
    t_new = (q_new == m_in);
  end
endmodule

// File: rtl/div1_step.sv
module div1_step
  import div1_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] divisor,
  input  logic [W-1:0] rem_in,
  input  logic         q_in,
  input  logic         m_in,
  input  logic         t_in,
  output logic [W-1:0] rem_nxt,
  output logic         q_nxt,
  output logic         t_nxt
);
  logic [W-1:0] opnd;
  logic         msb;
  logic         cb;
  div1_op_e     op;

  assign msb  = rem_in[W-1];
  assign opnd = {rem_in[W-2:0], t_in};
  assign op   = (q_in == m_in) ? OP_SUB : OP_ADD;

  div1_alu #(.W(W)) u_alu (
    .opnd    (opnd),
    .divisor (divisor),
    .op      (op),
    .res     (rem_nxt),
    .cb      (cb)
  );

  div1_flags u_flags (
    .shifted_out (msb),
    .cb          (cb),
    .m_in        (m_in),
    .q_new       (q_nxt),
    .t_new       (t_nxt)
  );
endmodule

// File: rtl/div1_unit.sv
module div1_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] divisor,
  input  logic [W-1:0] rem_in,
  input  logic         q_in,
  input  logic         m_in,
  input  logic         t_in,
  output logic [W-1:0] rem_out,
  output logic         q_out,
  output logic         t_out,
  output logic         valid
);
  logic [W-1:0] rem_nxt;
  logic         q_nxt;
  logic         t_nxt;

  div1_step #(.W(W)) u_step (
    .divisor (divisor),
    .rem_in  (rem_in),
    .q_in    (q_in),
    .m_in    (m_in),
    .t_in    (t_in),
    .rem_nxt (rem_nxt),
    .q_nxt   (q_nxt),
    .t_nxt   (t_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_out <= '0;
      q_out   <= 1'b0;
      t_out   <= 1'b0;
      valid   <= 1'b0;
    end else begin
      valid <= start;
      if (start) begin
        rem_out <= rem_nxt;
        q_out   <= q_nxt;
        t_out   <= t_nxt;
      end
    end
  end
endmodule

// File: rtl/div1_unit_chk.sv
module div1_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [W-1:0] divisor,
  input logic [W-1:0] rem_in,
  input logic         q_in,
  input logic         m_in,
  input logic         t_in,
  input logic [W-1:0] rem_out,
  input logic         q_out,
  input logic         t_out,
  input logic         valid
);
  // R2
  valid_follows_start_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> valid);

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !start |=> (!valid && $stable(rem_out) && $stable(q_out) && $stable(t_out)));

  // R4
  sub_result_chk: assert property (@(posedge clk) disable iff (rst)
    (start && (q_in == m_in)) |=>
      (rem_out == $past({rem_in[W-2:0], t_in} - divisor)));

  // R5
  add_result_chk: assert property (@(posedge clk) disable iff (rst)
    (start && (q_in != m_in)) |=>
      (rem_out == $past({rem_in[W-2:0], t_in} + divisor)));

  // R7
  t_from_q_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (t_out == (q_out == $past(m_in))));
endmodule

bind div1_unit div1_unit_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .divisor (divisor),
  .rem_in  (rem_in),
  .q_in    (q_in),
  .m_in    (m_in),
  .t_in    (t_in),
  .rem_out (rem_out),
  .q_out   (q_out),
  .t_out   (t_out),
  .valid   (valid)
);

// File: tb/tb_div1_unit.sv
`timescale 1ns/1ps
module tb_div1_unit;
  localparam int W    = 6;
  localparam int SPAN = 1 << W;
  localparam int MASK = SPAN - 1;

  logic         clk = 1'b0;
  logic         rst;
  logic         start;
  logic [W-1:0] divisor;
  logic [W-1:0] rem_in;
  logic         q_in, m_in, t_in;
  logic [W-1:0] rem_out;
  logic         q_out, t_out, valid;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  div1_unit #(.W(W)) dut (
    .clk(clk), .rst(rst), .start(start), .divisor(divisor), .rem_in(rem_in),
    .q_in(q_in), .m_in(m_in), .t_in(t_in), .rem_out(rem_out), .q_out(q_out),
    .t_out(t_out), .valid(valid)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one step; called at a falling edge, returns at the next falling edge
  task automatic step(input int d, input int r, input bit q, input bit m, input bit t);
    divisor = d[W-1:0];
    rem_in  = r[W-1:0];
    q_in = q; m_in = m; t_in = t;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_div(input int a, input int b, output int quo);
    int lo, hi;
    bit q, t, nt;
    lo = a; hi = 0; q = 0; t = 0;
    for (int i = 0; i < W; i++) begin
      nt = bit'((lo >> (W - 1)) & 1);
      lo = ((lo << 1) | int'(t)) & MASK;
      t  = nt;
      step(b, hi, q, 1'b0, t);
      hi = int'(rem_out); q = q_out; t = t_out;
    end
    lo  = ((lo << 1) | int'(t)) & MASK;
    quo = lo;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int shv, resv, quo, hold_rem;
    bit sub, cb, eq, et, hold_q, hold_t;
    rst = 1'b1; start = 1'b0; divisor = '0; rem_in = '0;
    q_in = 0; m_in = 0; t_in = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 valid", int'(valid), 0);
    chk("R1 rem_out", int'(rem_out), 0);
    chk("R1 q_out", int'(q_out), 0);
    chk("R1 t_out", int'(t_out), 0);
    rst = 1'b0;

    // R3 shift and T insertion, zero divisor leaves S unchanged
    step(0, 6'b100101, 1'b0, 1'b0, 1'b1);
    chk("R3 shift t=1", int'(rem_out), 6'b001011);
    step(0, 6'b011010, 1'b1, 1'b0, 1'b0);
    chk("R3 shift t=0", int'(rem_out), 6'b110100);

    // exhaustive single steps: R4 R5 R6 R7
    for (int d = 0; d < SPAN; d++) begin
      for (int r = 0; r < SPAN; r++) begin
        for (int f = 0; f < 8; f++) begin
          bit q, m, t;
          q = f[2]; m = f[1]; t = f[0];
          step(d, r, q, m, t);
          shv = ((r << 1) | int'(t)) & MASK;
          sub = (q == m);
          if (sub) begin
            resv = (shv - d) & MASK;
            cb   = (shv < d);
          end else begin
            resv = (shv + d) & MASK;
            cb   = ((shv + d) > MASK);
          end
          eq = bit'((r >> (W - 1)) & 1) ^ cb ^ m;
          et = (eq == m);
          if (sub) chk("R4 subtract", int'(rem_out), resv);
          else     chk("R5 add", int'(rem_out), resv);
          chk("R6 q_out", int'(q_out), int'(eq));
          chk("R7 t_out", int'(t_out), int'(et));
          if (!valid) chk("R2 valid on start", int'(valid), 1);
        end
      end
    end

    // R2 idle cycle holds outputs, drops valid
    hold_rem = int'(rem_out); hold_q = q_out; hold_t = t_out;
    start = 1'b0;
    rem_in = ~rem_in; divisor = ~divisor; t_in = ~t_in;
    @(posedge clk);
    @(negedge clk);
    chk("R2 valid low", int'(valid), 0);
    chk("R2 rem hold", int'(rem_out), hold_rem);
    chk("R2 q hold", int'(q_out), int'(hold_q));
    chk("R2 t hold", int'(t_out), int'(hold_t));

    // R8 full unsigned divisions, every dividend by every nonzero divisor
    for (int b = 1; b < SPAN; b++) begin
      for (int a = 0; a < SPAN; a++) begin
        run_div(a, b, quo);
        chk("R8 quotient", quo, a / b);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule